// File: doc/BRIEF.md
# Two-Bank Interleaved Secondary Cache Access Pipeline

This block controls an external secondary cache built from synchronous SRAM. The cache is split into an even bank and an odd bank, chosen by the lowest bit of the word address. Two requesters share the block: an integer-side port and a floating-point-side port. Each cycle the block accepts up to two requests and steers each one to its bank. Two accepted requests may be any mix of reads and writes, as long as they go to different banks. When both target the same bank, the integer side wins and the floating-point side sees ready low for that cycle.

Each bank runs its own five-stage access pipeline. In stage 1 the set index goes to that bank's copy of the tag array. Stage 2 compares the four ways. Stage 3 drives the data SRAM, with the hitting way number used as the upper SRAM address bits. Stage 4 is the SRAM access. Stage 5 returns a response carrying the requester's source and id. A tag miss suppresses the SRAM access and returns a miss response at the same fixed latency.

Each bank has a separate read data bus and a separate write data bus, so a read and a write to the same bank can occupy consecutive cycles with no idle cycle between them. A tag update presented at the block is forwarded one cycle later to both tag copies with identical contents. The tag and data SRAMs themselves live outside the block.

Top module: `l2p_top`

## Requirements
- R1: The bank of a request is address bit 0 (0 = even, 1 = odd). A request travels only through that bank's pipeline, and its response appears only on that bank's response lanes.
- R2: The block accepts two requests in one cycle whenever their bank bits differ: two reads, two writes, or one of each. Both ready outputs are high in that cycle.
- R3: When both requesters are valid to the same bank in a cycle, the integer request is accepted and fpReady is low. A floating-point request that is held stays waiting and is accepted in the next cycle that has no conflict.
- R4: A request accepted in cycle c produces rspValid on its bank in cycle c+5 and not earlier. Responses on a bank leave in acceptance order.
- R5: The tag index (address bits IDX_W:1) is presented on tagRdIdx in cycle c+1. The tag array returns its entries one cycle later.
- R6: Tag lookup works as follows:
  - The tag field is address bits ADDR_W-1:IDX_W+1.
  - Way w occupies bits [w*(TAG_W+1) +: TAG_W+1] of the bank's tag read bus. The top bit of that field is the valid flag and the lower TAG_W bits are the tag.
  - A way hits when its valid flag is 1 and its tag equals the request's tag field.
  - On a hit the SRAM is accessed in cycle c+3 at address {way, index}.
  - A read hit returns the SRAM word as rspData with rspHit = 1.
- R7: On a tag miss there is no SRAM read or write for that request. The response has rspHit = 0 and rspData = 0, and it still carries the requester's id and source. A write that misses leaves the SRAM contents unchanged.
- R8: A write hit drives sramWe with the request's data on the bank's write bus in cycle c+3. Its response has rspHit = 1, rspWrite = 1 and rspData = 0.
- R9: A read to the same bank in the cycle after a write returns the newly written data. A write in the cycle after a read is accepted with no idle cycle, and the read returns the old data.
- R10: A tag update presented in cycle t drives tagWe = 2'b11 in cycle t+1, with the same index, way, tag and valid flag going to both copies. tagWe is 2'b00 when no update was presented.
- R11: In reset and directly after it, rspValid, sramRe, sramWe and tagWe are all zero.
- R12: rspSrc is 0 for an integer-side request and 1 for a floating-point-side request. rspId echoes the id given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intValid | input | 1 | Integer-side request valid |
| intReady | output | 1 | Integer-side request accepted |
| intWrite | input | 1 | Integer-side request is a write |
| intAddr | input | ADDR_W | Integer-side word address |
| intWdata | input | DATA_W | Integer-side write data |
| intId | input | ID_W | Integer-side requester tag |
| fpValid | input | 1 | Floating-point-side request valid |
| fpReady | output | 1 | Floating-point-side request accepted |
| fpWrite | input | 1 | Floating-point-side request is a write |
| fpAddr | input | ADDR_W | Floating-point-side word address |
| fpWdata | input | DATA_W | Floating-point-side write data |
| fpId | input | ID_W | Floating-point-side requester tag |
| tuValid | input | 1 | Tag update request |
| tuIdx | input | IDX_W | Tag update set index |
| tuWay | input | WAY_W | Tag update way |
| tuTag | input | TAG_W | Tag update tag value |
| tuLive | input | 1 | Tag update valid flag |
| tagRdIdx | output | 2 x IDX_W | Tag read index per bank |
| tagRdData | input | 2 x WAYS*(TAG_W+1) | Tag entries per bank, one cycle after index |
| tagWe | output | 2 | Tag write enable per bank copy |
| tagWIdx | output | IDX_W | Tag write index |
| tagWWay | output | WAY_W | Tag write way |
| tagWTag | output | TAG_W | Tag write tag value |
| tagWLive | output | 1 | Tag write valid flag |
| sramAddr | output | 2 x (WAY_W+IDX_W) | Data SRAM address per bank |
| sramRe | output | 2 | Data SRAM read enable per bank |
| sramWe | output | 2 | Data SRAM write enable per bank |
| sramWdata | output | 2 x DATA_W | Write data bus per bank |
| sramRdata | input | 2 x DATA_W | Read data bus per bank, one cycle after read enable |
| rspValid | output | 2 | Response valid per bank |
| rspHit | output | 2 | Response was a tag hit |
| rspWrite | output | 2 | Response belongs to a write |
| rspSrc | output | 2 | Response source, 0 integer, 1 floating-point |
| rspId | output | 2 x ID_W | Response requester tag |
| rspData | output | 2 x DATA_W | Response read data |

## Verification
The two functions that meet in one cycle are dual acceptance across banks and same-bank arbitration. Both are driven by the same pair of request ports and the same ready logic.

The bench provokes dual acceptance by presenting integer and floating-point requests together with different bank bits. It provokes arbitration by presenting them together with equal bank bits. It judges the outcome from the ready outputs in that cycle and from which bank lanes respond. In the conflict case it also checks that the held floating-point response arrives exactly one cycle after the integer response on the same bank.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
  localparam int NUM_BANKS = 2;
  localparam int PIPE_DEPTH = 5;

  typedef struct packed {
    logic acc;
    logic src;
    logic v3;
  } bankStrb_t;
endpackage

// File: rtl/l2p_tag_cmp.sv
module l2p_tag_cmp #(
  parameter int TAG_W = 11,
  parameter int WAYS = 4
) (
  input  logic [WAYS*(TAG_W+1)-1:0] entries,
  input  logic [TAG_W-1:0]          lookTag,
  output logic                      hit,
  output logic [$clog2(WAYS)-1:0]   way
);
  localparam int ENT_W = TAG_W + 1;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = entries[w*ENT_W + TAG_W] &&
                      (entries[w*ENT_W +: TAG_W] == lookTag);
  end

  always_comb begin
    hit = |match;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/l2p_ctrl.sv
module l2p_ctrl
  import l2p_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           intValid,
  input  logic                           intBank,
  input  logic                           fpValid,
  input  logic                           fpBank,
  output logic                           intReady,
  output logic                           fpReady,
  input  logic                           tuValid,
  input  logic [IDX_W-1:0]               tuIdx,
  input  logic [WAY_W-1:0]               tuWay,
  input  logic [TAG_W-1:0]               tuTag,
  input  logic                           tuLive,
  output logic [NUM_BANKS-1:0]           tagWe,
  output logic [IDX_W-1:0]               tagWIdx,
  output logic [WAY_W-1:0]               tagWWay,
  output logic [TAG_W-1:0]               tagWTag,
  output logic                           tagWLive,
  output bankStrb_t [NUM_BANKS-1:0]      strb,
  output logic [NUM_BANKS-1:0]           rspValid
);
  assign intReady = 1'b1;
  assign fpReady  = !(intValid && fpValid && (intBank == fpBank));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic intTake;
    logic fpTake;
    logic [PIPE_DEPTH-1:0] stageV;

    assign intTake = intValid && (intBank == 1'(b));
    assign fpTake  = fpValid && fpReady && (fpBank == 1'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageV <= '0;
      else       stageV <= {stageV[PIPE_DEPTH-2:0], intTake || fpTake};
    end

    assign strb[b].acc  = intTake || fpTake;
    assign strb[b].src  = !intTake;
    assign strb[b].v3   = stageV[2];
    assign rspValid[b]  = stageV[PIPE_DEPTH-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagWe    <= '0;
      tagWIdx  <= '0;
      tagWWay  <= '0;
      tagWTag  <= '0;
      tagWLive <= 1'b0;
    end else begin
      tagWe <= {NUM_BANKS{tuValid}};
      if (tuValid) begin
        tagWIdx  <= tuIdx;
        tagWWay  <= tuWay;
        tagWTag  <= tuTag;
        tagWLive <= tuLive;
      end
    end
  end
endmodule

// File: rtl/l2p_bank_dp.sv
module l2p_bank_dp
  import l2p_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ID_W = 4,
  parameter int IDX_W = 4,
  parameter int WAYS = 4
) (
  input  logic                            clk,
  input  bankStrb_t                       strb,
  input  logic                            intWrite,
  input  logic [ADDR_W-2:0]               intLine,
  input  logic [DATA_W-1:0]               intWdata,
  input  logic [ID_W-1:0]                 intId,
  input  logic                            fpWrite,
  input  logic [ADDR_W-2:0]               fpLine,
  input  logic [DATA_W-1:0]               fpWdata,
  input  logic [ID_W-1:0]                 fpId,
  output logic [IDX_W-1:0]                tagRdIdx,
  input  logic [WAYS*(ADDR_W-IDX_W)-1:0]  tagRdData,
  output logic [$clog2(WAYS)+IDX_W-1:0]   sramAddr,
  output logic                            sramRe,
  output logic                            sramWe,
  output logic [DATA_W-1:0]               sramWdata,
  input  logic [DATA_W-1:0]               sramRdata,
  output logic                            rspHit,
  output logic                            rspWrite,
  output logic                            rspSrc,
  output logic [ID_W-1:0]                 rspId,
  output logic [DATA_W-1:0]               rspData
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - 1 - IDX_W;

  logic [ADDR_W-2:0] s1Line, s2Line;
  logic [IDX_W-1:0]  s3Idx;
  logic              s1Wr, s2Wr, s3Wr, s4Wr;
  logic              s1Src, s2Src, s3Src, s4Src;
  logic [ID_W-1:0]   s1Id, s2Id, s3Id, s4Id;
  logic [DATA_W-1:0] s1Wd, s2Wd, s3Wd;
  logic              s3Hit, s4Hit;
  logic [WAY_W-1:0]  s3Way;
  logic              hit2;
  logic [WAY_W-1:0]  way2;

  l2p_tag_cmp #(.TAG_W(TAG_W), .WAYS(WAYS)) u_cmp (
    .entries (tagRdData),
    .lookTag (s2Line[ADDR_W-2:IDX_W]),
    .hit     (hit2),
    .way     (way2)
  );

  always_ff @(posedge clk) begin
    s1Line <= strb.src ? fpLine  : intLine;
    s1Wr   <= strb.src ? fpWrite : intWrite;
    s1Wd   <= strb.src ? fpWdata : intWdata;
    s1Id   <= strb.src ? fpId    : intId;
    s1Src  <= strb.src;

    s2Line <= s1Line;
    s2Wr   <= s1Wr;
    s2Wd   <= s1Wd;
    s2Id   <= s1Id;
    s2Src  <= s1Src;

    s3Idx  <= s2Line[IDX_W-1:0];
    s3Wr   <= s2Wr;
    s3Wd   <= s2Wd;
    s3Id   <= s2Id;
    s3Src  <= s2Src;
    s3Hit  <= hit2;
    s3Way  <= way2;

    s4Wr   <= s3Wr;
    s4Id   <= s3Id;
    s4Src  <= s3Src;
    s4Hit  <= s3Hit;

    rspHit   <= s4Hit;
    rspWrite <= s4Wr;
    rspSrc   <= s4Src;
    rspId    <= s4Id;
    rspData  <= (s4Hit && !s4Wr) ? sramRdata : '0;
  end

  assign tagRdIdx  = s1Line[IDX_W-1:0];
  assign sramAddr  = {s3Way, s3Idx};
  assign sramRe    = strb.v3 && s3Hit && !s3Wr;
  assign sramWe    = strb.v3 && s3Hit && s3Wr;
  assign sramWdata = s3Wd;
endmodule

// File: rtl/l2p_top.sv
module l2p_top
  import l2p_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ID_W = 4,
  parameter int IDX_W = 4,
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - 1 - IDX_W,
  localparam int ENT_W = TAG_W + 1,
  localparam int SADDR_W = WAY_W + IDX_W
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                intValid,
  output logic                                intReady,
  input  logic                                intWrite,
  input  logic [ADDR_W-1:0]                   intAddr,
  input  logic [DATA_W-1:0]                   intWdata,
  input  logic [ID_W-1:0]                     intId,
  input  logic                                fpValid,
  output logic                                fpReady,
  input  logic                                fpWrite,
  input  logic [ADDR_W-1:0]                   fpAddr,
  input  logic [DATA_W-1:0]                   fpWdata,
  input  logic [ID_W-1:0]                     fpId,
  input  logic                                tuValid,
  input  logic [IDX_W-1:0]                    tuIdx,
  input  logic [WAY_W-1:0]                    tuWay,
  input  logic [TAG_W-1:0]                    tuTag,
  input  logic                                tuLive,
  output logic [1:0][IDX_W-1:0]               tagRdIdx,
  input  logic [1:0][WAYS*ENT_W-1:0]          tagRdData,
  output logic [1:0]                          tagWe,
  output logic [IDX_W-1:0]                    tagWIdx,
  output logic [WAY_W-1:0]                    tagWWay,
  output logic [TAG_W-1:0]                    tagWTag,
  output logic                                tagWLive,
  output logic [1:0][SADDR_W-1:0]             sramAddr,
  output logic [1:0]                          sramRe,
  output logic [1:0]                          sramWe,
  output logic [1:0][DATA_W-1:0]              sramWdata,
  input  logic [1:0][DATA_W-1:0]              sramRdata,
  output logic [1:0]                          rspValid,
  output logic [1:0]                          rspHit,
  output logic [1:0]                          rspWrite,
  output logic [1:0]                          rspSrc,
  output logic [1:0][ID_W-1:0]                rspId,
  output logic [1:0][DATA_W-1:0]              rspData
);
  bankStrb_t [NUM_BANKS-1:0] strb;

  l2p_ctrl #(.IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .intValid (intValid),
    .intBank  (intAddr[0]),
    .fpValid  (fpValid),
    .fpBank   (fpAddr[0]),
    .intReady (intReady),
    .fpReady  (fpReady),
    .tuValid  (tuValid),
    .tuIdx    (tuIdx),
    .tuWay    (tuWay),
    .tuTag    (tuTag),
    .tuLive   (tuLive),
    .tagWe    (tagWe),
    .tagWIdx  (tagWIdx),
    .tagWWay  (tagWWay),
    .tagWTag  (tagWTag),
    .tagWLive (tagWLive),
    .strb     (strb),
    .rspValid (rspValid)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    l2p_bank_dp #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .IDX_W(IDX_W), .WAYS(WAYS)
    ) u_dp (
      .clk       (clk),
      .strb      (strb[b]),
      .intWrite  (intWrite),
      .intLine   (intAddr[ADDR_W-1:1]),
      .intWdata  (intWdata),
      .intId     (intId),
      .fpWrite   (fpWrite),
      .fpLine    (fpAddr[ADDR_W-1:1]),
      .fpWdata   (fpWdata),
      .fpId      (fpId),
      .tagRdIdx  (tagRdIdx[b]),
      .tagRdData (tagRdData[b]),
      .sramAddr  (sramAddr[b]),
      .sramRe    (sramRe[b]),
      .sramWe    (sramWe[b]),
      .sramWdata (sramWdata[b]),
      .sramRdata (sramRdata[b]),
      .rspHit    (rspHit[b]),
      .rspWrite  (rspWrite[b]),
      .rspSrc    (rspSrc[b]),
      .rspId     (rspId[b]),
      .rspData   (rspData[b])
    );
  end
endmodule

// File: rtl/l2p_chk.sv
module l2p_chk (
  input logic       clk,
  input logic       rstN,
  input logic       intValid,
  input logic       intReady,
  input logic       intBank,
  input logic       fpValid,
  input logic       fpReady,
  input logic       fpBank,
  input logic       tuValid,
  input logic [1:0] tagWe,
  input logic [1:0] sramRe,
  input logic [1:0] sramWe,
  input logic [1:0] rspValid,
  input logic [1:0] rspHit,
  input logic [1:0] rspWrite
);
  logic [1:0] acc;
  assign acc[0] = (intValid && intReady && !intBank) || (fpValid && fpReady && !fpBank);
  assign acc[1] = (intValid && intReady && intBank) || (fpValid && fpReady && fpBank);

  // R2
  dual_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intValid && fpValid && (intBank != fpBank)) |-> (intReady && fpReady));

  // R3
  int_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intValid && fpValid && (intBank == fpBank)) |-> (intReady && !fpReady));

  // R4
  latency_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc[0] |-> ##5 rspValid[0]);

  // R4
  latency_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc[1] |-> ##5 rspValid[1]);

  // R6
  read_hit_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid[0] && rspHit[0] && !rspWrite[0]) |-> $past(sramRe[0], 2));

  // R6
  read_hit_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid[1] && rspHit[1] && !rspWrite[1]) |-> $past(sramRe[1], 2));

  // R7
  miss_quiet_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid[0] && !rspHit[0]) |-> $past(!sramRe[0] && !sramWe[0], 2));

  // R7
  miss_quiet_odd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid[1] && !rspHit[1]) |-> $past(!sramRe[1] && !sramWe[1], 2));

  // R8
  write_hit_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid[0] && rspHit[0] && rspWrite[0]) |-> $past(sramWe[0], 2));

  // R10
  tag_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    tuValid |=> (tagWe == 2'b11));

  // R10
  tag_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tuValid |=> (tagWe == 2'b00));
endmodule

bind l2p_top l2p_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .intValid (intValid),
  .intReady (intReady),
  .intBank  (intAddr[0]),
  .fpValid  (fpValid),
  .fpReady  (fpReady),
  .fpBank   (fpAddr[0]),
  .tuValid  (tuValid),
  .tagWe    (tagWe),
  .sramRe   (sramRe),
  .sramWe   (sramWe),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspWrite (rspWrite)
);

// File: tb/tb_l2p_top.sv
`timescale 1ns/1ps
module tb_l2p_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int ID_W = 4;
  localparam int IDX_W = 4;
  localparam int WAYS = 4;
  localparam int WAY_W = 2;
  localparam int TAG_W = ADDR_W - 1 - IDX_W;
  localparam int ENT_W = TAG_W + 1;
  localparam int SADDR_W = WAY_W + IDX_W;
  localparam int SETS = 1 << IDX_W;
  localparam int SDEPTH = 1 << SADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intValid = 1'b0, intWrite = 1'b0;
  logic [ADDR_W-1:0] intAddr = '0;
  logic [DATA_W-1:0] intWdata = '0;
  logic [ID_W-1:0] intId = '0;
  logic fpValid = 1'b0, fpWrite = 1'b0;
  logic [ADDR_W-1:0] fpAddr = '0;
  logic [DATA_W-1:0] fpWdata = '0;
  logic [ID_W-1:0] fpId = '0;
  logic tuValid = 1'b0, tuLive = 1'b0;
  logic [IDX_W-1:0] tuIdx = '0;
  logic [WAY_W-1:0] tuWay = '0;
  logic [TAG_W-1:0] tuTag = '0;
  logic intReady, fpReady;
  logic [1:0][IDX_W-1:0] tagRdIdx;
  logic [1:0][WAYS*ENT_W-1:0] tagRdData;
  logic [1:0] tagWe;
  logic [IDX_W-1:0] tagWIdx;
  logic [WAY_W-1:0] tagWWay;
  logic [TAG_W-1:0] tagWTag;
  logic tagWLive;
  logic [1:0][SADDR_W-1:0] sramAddr;
  logic [1:0] sramRe, sramWe;
  logic [1:0][DATA_W-1:0] sramWdata;
  logic [1:0][DATA_W-1:0] sramRdata;
  logic [1:0] rspValid, rspHit, rspWrite, rspSrc;
  logic [1:0][ID_W-1:0] rspId;
  logic [1:0][DATA_W-1:0] rspData;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  l2p_top dut (.*);

  function automatic logic [DATA_W-1:0] pat(int b, int a);
    return {32'hCAFE_0000 + 32'(b * 256 + a), 32'h0BAD_0000 + 32'(a)};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i, logic b);
    return {t, i, b};
  endfunction

  // behavioural tag copies, one per bank
  logic [TAG_W:0] tagMem [2][SETS][WAYS];
  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!rstN) begin
        for (int i = 0; i < SETS; i++)
          for (int w = 0; w < WAYS; w++) tagMem[b][i][w] <= '0;
      end else if (tagWe[b]) begin
        tagMem[b][tagWIdx][tagWWay] <= {tagWLive, tagWTag};
      end
      for (int w = 0; w < WAYS; w++)
        tagRdData[b][w*ENT_W +: ENT_W] <= tagMem[b][tagRdIdx[b]][w];
    end
  end

  // behavioural data SRAM, one per bank
  logic [DATA_W-1:0] sMem [2][SDEPTH];
  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!rstN) begin
        for (int a = 0; a < SDEPTH; a++) sMem[b][a] <= pat(b, a);
      end else begin
        if (sramWe[b]) sMem[b][sramAddr[b]] <= sramWdata[b];
        if (sramRe[b]) sramRdata[b] <= sMem[b][sramAddr[b]];
      end
    end
  end

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkRsp(int b, string tag, logic hit, logic wr, logic src,
                        logic [ID_W-1:0] id, logic [DATA_W-1:0] data);
    chk({tag, " valid"}, 64'(rspValid[b]), 64'(1'b1));
    chk({tag, " hit"}, 64'(rspHit[b]), 64'(hit));
    chk({tag, " write"}, 64'(rspWrite[b]), 64'(wr));
    chk({tag, " src R12"}, 64'(rspSrc[b]), 64'(src));
    chk({tag, " id R12"}, 64'(rspId[b]), 64'(id));
    chk({tag, " data"}, rspData[b], data);
  endtask

  task automatic setInt(logic wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [ID_W-1:0] id);
    intValid = 1'b1; intWrite = wr; intAddr = a; intWdata = d; intId = id;
  endtask

  task automatic setFp(logic wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [ID_W-1:0] id);
    fpValid = 1'b1; fpWrite = wr; fpAddr = a; fpWdata = d; fpId = id;
  endtask

  task automatic clrInt(); intValid = 1'b0; intWrite = 1'b0; endtask
  task automatic clrFp();  fpValid = 1'b0; fpWrite = 1'b0; endtask

  task automatic tResetState();
    chk("R11 rspValid", 64'(rspValid), 64'(0));
    chk("R11 sramRe", 64'(sramRe), 64'(0));
    chk("R11 sramWe", 64'(sramWe), 64'(0));
    chk("R11 tagWe", 64'(tagWe), 64'(0));
  endtask

  task automatic tInstall(logic [IDX_W-1:0] idx, logic [WAY_W-1:0] way, logic [TAG_W-1:0] t);
    @(negedge clk);
    tuValid = 1'b1; tuIdx = idx; tuWay = way; tuTag = t; tuLive = 1'b1;
    @(negedge clk);
    tuValid = 1'b0;
    chk("R10 both copies", 64'(tagWe), 64'(2'b11));
    chk("R10 index", 64'(tagWIdx), 64'(idx));
    chk("R10 way", 64'(tagWWay), 64'(way));
    chk("R10 tag", 64'(tagWTag), 64'(t));
    chk("R10 live", 64'(tagWLive), 64'(1'b1));
    @(negedge clk);
    chk("R10 idle", 64'(tagWe), 64'(2'b00));
  endtask

  // single read on one bank, latency exact
  task automatic tSingle(logic useFp, logic [ADDR_W-1:0] a, logic [ID_W-1:0] id,
                         logic [DATA_W-1:0] exp, string tag);
    int b = int'(a[0]);
    @(negedge clk);
    if (useFp) setFp(1'b0, a, '0, id); else setInt(1'b0, a, '0, id);
    @(negedge clk);
    clrInt(); clrFp();
    chk({tag, " R5 tag index"}, 64'(tagRdIdx[b]), 64'(a[IDX_W:1]));
    repeat (3) @(negedge clk);
    chk({tag, " R4 not early"}, 64'(rspValid[b]), 64'(0));
    @(negedge clk);
    chkRsp(b, {tag, " R4 R6"}, 1'b1, 1'b0, useFp, id, exp);
    chk({tag, " R1 other bank idle"}, 64'(rspValid[1-b]), 64'(0));
  endtask

  task automatic tDualBanks();
    @(negedge clk);
    setInt(1'b0, mk(11'h0AA, 4'd5, 1'b1), '0, 4'h1);
    setFp(1'b0, mk(11'h155, 4'd3, 1'b0), '0, 4'h2);
    #1;
    chk("R2 int ready", 64'(intReady), 64'(1));
    chk("R2 fp ready", 64'(fpReady), 64'(1));
    @(negedge clk);
    clrInt(); clrFp();
    repeat (4) @(negedge clk);
    chkRsp(1, "R2 R1 odd int", 1'b1, 1'b0, 1'b0, 4'h1, pat(1, 5));
    chkRsp(0, "R2 R1 even fp", 1'b1, 1'b0, 1'b1, 4'h2, pat(0, 35));
  endtask

  task automatic tConflict();
    @(negedge clk);
    setInt(1'b0, mk(11'h0AA, 4'd5, 1'b0), '0, 4'h3);
    setFp(1'b0, mk(11'h3C3, 4'd3, 1'b0), '0, 4'h4);
    #1;
    chk("R3 int wins", 64'(intReady), 64'(1));
    chk("R3 fp held", 64'(fpReady), 64'(0));
    @(negedge clk);
    clrInt();
    #1;
    chk("R3 fp taken next", 64'(fpReady), 64'(1));
    @(negedge clk);
    clrFp();
    repeat (3) @(negedge clk);
    chkRsp(0, "R3 R4 int first", 1'b1, 1'b0, 1'b0, 4'h3, pat(0, 5));
    @(negedge clk);
    chkRsp(0, "R3 R4 fp second", 1'b1, 1'b0, 1'b1, 4'h4, pat(0, 19));
  endtask

  task automatic tMiss();
    // read miss
    @(negedge clk);
    setInt(1'b0, mk(11'h7FF, 4'd3, 1'b0), '0, 4'h5);
    @(negedge clk);
    clrInt();
    repeat (4) @(negedge clk);
    chkRsp(0, "R7 read miss", 1'b0, 1'b0, 1'b0, 4'h5, '0);
    // write miss must leave SRAM untouched
    @(negedge clk);
    setFp(1'b1, mk(11'h7FF, 4'd6, 1'b1), 64'hDEAD_BEEF_0000_0001, 4'h6);
    @(negedge clk);
    clrFp();
    repeat (4) @(negedge clk);
    chkRsp(1, "R7 write miss", 1'b0, 1'b1, 1'b1, 4'h6, '0);
    tInstall(4'd6, 2'd3, 11'h7FF);
    tSingle(1'b0, mk(11'h7FF, 4'd6, 1'b1), 4'h7, pat(1, 54), "R7 untouched");
  endtask

  task automatic tWriteThenRead();
    logic [DATA_W-1:0] d1 = 64'h1111_2222_3333_4444;
    @(negedge clk);
    setInt(1'b1, mk(11'h155, 4'd3, 1'b0), d1, 4'h8);
    @(negedge clk);
    setInt(1'b0, mk(11'h155, 4'd3, 1'b0), '0, 4'h9);
    @(negedge clk);
    clrInt();
    @(negedge clk);
    chk("R8 write bus enable", 64'(sramWe[0]), 64'(1));
    chk("R8 write bus data", sramWdata[0], d1);
    chk("R8 write address", 64'(sramAddr[0]), 64'(35));
    repeat (2) @(negedge clk);
    chkRsp(0, "R8 write hit", 1'b1, 1'b1, 1'b0, 4'h8, '0);
    @(negedge clk);
    chkRsp(0, "R9 read after write", 1'b1, 1'b0, 1'b0, 4'h9, d1);
  endtask

  task automatic tReadThenWrite();
    logic [DATA_W-1:0] d2 = 64'h5555_6666_7777_8888;
    @(negedge clk);
    setInt(1'b0, mk(11'h0AA, 4'd5, 1'b0), '0, 4'hA);
    @(negedge clk);
    clrInt();
    setFp(1'b1, mk(11'h0AA, 4'd5, 1'b0), d2, 4'hB);
    #1;
    chk("R9 write no gap", 64'(fpReady), 64'(1));
    @(negedge clk);
    clrFp();
    repeat (3) @(negedge clk);
    chkRsp(0, "R9 read old", 1'b1, 1'b0, 1'b0, 4'hA, pat(0, 5));
    @(negedge clk);
    chkRsp(0, "R9 write next", 1'b1, 1'b1, 1'b1, 4'hB, '0);
    tSingle(1'b0, mk(11'h0AA, 4'd5, 1'b0), 4'hC, d2, "R9 new value");
  endtask

  task automatic tDualWrites();
    logic [DATA_W-1:0] d3 = 64'h0303_0303_0303_0303;
    logic [DATA_W-1:0] d4 = 64'h0404_0404_0404_0404;
    @(negedge clk);
    setInt(1'b1, mk(11'h3C3, 4'd3, 1'b0), d3, 4'hD);
    setFp(1'b1, mk(11'h3C3, 4'd3, 1'b1), d4, 4'hE);
    #1;
    chk("R2 dual write fp ready", 64'(fpReady), 64'(1));
    @(negedge clk);
    setInt(1'b0, mk(11'h3C3, 4'd3, 1'b1), '0, 4'h1);
    setFp(1'b0, mk(11'h3C3, 4'd3, 1'b0), '0, 4'h2);
    @(negedge clk);
    clrInt(); clrFp();
    repeat (3) @(negedge clk);
    chkRsp(0, "R2 write even", 1'b1, 1'b1, 1'b0, 4'hD, '0);
    chkRsp(1, "R2 write odd", 1'b1, 1'b1, 1'b1, 4'hE, '0);
    @(negedge clk);
    chkRsp(1, "R2 readback odd", 1'b1, 1'b0, 1'b0, 4'h1, d4);
    chkRsp(0, "R2 readback even", 1'b1, 1'b0, 1'b1, 4'h2, d3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tInstall(4'd3, 2'd2, 11'h155);
    tInstall(4'd5, 2'd0, 11'h0AA);
    tInstall(4'd3, 2'd1, 11'h3C3);
    tSingle(1'b0, mk(11'h155, 4'd3, 1'b0), 4'h1, pat(0, 35), "R6 int even way2");
    tSingle(1'b1, mk(11'h3C3, 4'd3, 1'b1), 4'h2, pat(1, 19), "R6 fp odd way1");
    tDualBanks();
    tConflict();
    tMiss();
    tWriteThenRead();
    tReadThenWrite();
    tDualWrites();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule